// File: doc/BRIEF.md
# Free-Running Timer with Buffered Period

This block is a free-running counter whose period is set by a compare-clear value. It has two counting modes. In up-count mode the count climbs and returns to zero on the clock after it equals the compare-clear value. In up/down mode the count climbs to the compare-clear value and then descends back to zero, over and over. The mode can be changed while the timer runs. The new counting rule picks up from the count at that moment, and no reset takes place.

The compare-clear value is written through a buffer that can be enabled or bypassed. With the buffer bypassed, a period write reaches the active compare-clear register at once. With the buffer enabled, the written value waits and is copied into the active register on the next enabled clock at which the count is zero. Software writes the period value and the control fields (mode, buffer enable, run) through two strobed write ports. A count enable gates each step. The outputs are one-clock match and zero pulses and the live count.

Top module: `freerun_period_timer`

## Requirements
- R1: After reset the count is 0, both pulses are 0, the mode is up-count, buffering is off, the active period is 0 and the timer is stopped, so `count_en_i` alone does not move the count.
- R2: The count changes only at a clock edge where the run bit is 1 and `count_en_i` is 1. Otherwise it holds its value and no pulse is produced.
- R3: In up-count mode (`ctrl_updown_i`=0 written), each enabled step adds 1. A step taken while the count equals the active period returns the count to 0.
- R4: In up/down mode (`ctrl_updown_i`=1 written), the count rises by 1 per step until it equals the active period. The following step begins the descent. It falls by 1 per step to 0, and the step from 0 rises again.
- R5: `match_o` is 1 for exactly the cycle after an enabled step that started with the count equal to the active period. `zero_o` is 1 for exactly the cycle after an enabled step that started with the count at 0.
- R6: With buffering off, a `wr_period_i` write replaces the active period at that edge. The next step is compared against the new value.
- R7: With buffering on, a `wr_period_i` write only fills the buffer. The active period is unchanged until an enabled step from count 0, and that step copies the buffer into it.
- R8: Switching to up-count mode while the count is descending makes the next enabled step add 1 to the current count.
- R9: Switching to up/down mode while counting up continues upward from the current count, with no reset.
- R10: If a buffered value is pending and buffering is then turned off, the next direct period write replaces the pending value. The count then wraps at the directly written period.
- R11: With an active period of 0, the count stays at 0, and every enabled step raises both `match_o` and `zero_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_period_i | input | 1 | Strobe: write `wr_value_i` as the period value |
| wr_value_i | input | 16 | Period value to write |
| wr_ctrl_i | input | 1 | Strobe: load the three control fields below |
| ctrl_updown_i | input | 1 | Mode field: 0 up-count, 1 up/down |
| ctrl_buffer_i | input | 1 | Buffer enable field |
| ctrl_run_i | input | 1 | Run field |
| count_en_i | input | 1 | Per-clock count enable |
| count_o | output | 16 | Current count |
| match_o | output | 1 | One-clock compare-clear match pulse |
| zero_o | output | 1 | One-clock zero-detect pulse |

## Verification
The bench changes mode in the middle of a descent and in the middle of an ascent. A design that restarts the count, or that keeps the old direction, shows a wrong next count value. It lowers the period with a direct write while running. A design that latches the period late wraps at the old value. It leaves a buffered value pending, then checks that the active period holds through a whole cycle and loads only at the step from zero. A design that loads early or never loads wraps at the wrong count. The bench also overrides a pending value with a direct write, runs a zero period in up/down mode, and resets in the middle of a run. A design that gets either of the first two wrong wanders away from the expected wrap point or fails to pulse on every step.

// File: rtl/freerun_pkg.sv
package freerun_pkg;
  typedef enum logic {
    CNT_UP     = 1'b0,
    CNT_UPDOWN = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/freerun_period_regs.sv
module freerun_period_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_period_i,
  input  logic [W-1:0] wr_value_i,
  input  logic         buffered_i,
  input  logic         load_i,
  output logic [W-1:0] period_o
);
  logic [W-1:0] buf_q;
  logic [W-1:0] period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      period_q <= '0;
    end else begin
      if (wr_period_i) buf_q <= wr_value_i;
      if (!buffered_i && wr_period_i) period_q <= wr_value_i;
      else if (buffered_i && load_i) period_q <= buf_q;
    end
  end

  assign period_o = period_q;
endmodule

// File: rtl/freerun_count_core.sv
module freerun_count_core
  import freerun_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         match_evt_o,
  output logic         zero_evt_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         down_q;

  // returns {down_next, count_next}
  function automatic logic [W:0] next_state(input logic [W-1:0] c,
                                            input logic [W-1:0] p,
                                            input cnt_mode_e    m,
                                            input logic         dn);
    logic [W:0] r;
    if (m == CNT_UP) begin
      r = (c == p) ? {1'b0, {W{1'b0}}} : {1'b0, c + ONE};
    end else if (c == p) begin
      r = (p == '0) ? {1'b0, {W{1'b0}}} : {1'b1, c - ONE};
    end else if (c == '0) begin
      r = {1'b0, ONE};
    end else if (dn) begin
      r = {1'b1, c - ONE};
    end else begin
      r = {1'b0, c + ONE};
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (step_i) begin
      {down_q, cnt_q} <= next_state(cnt_q, period_i, mode_i, down_q);
    end
  end

  assign cnt_o       = cnt_q;
  assign down_o      = down_q;
  assign match_evt_o = step_i && (cnt_q == period_i);
  assign zero_evt_o  = step_i && (cnt_q == '0);
endmodule

// File: rtl/freerun_event_pulse.sv
module freerun_event_pulse #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] pulse_o
);
  for (genvar g = 0; g < N; g++) begin : g_pulse
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= evt_i[g];
    end
    assign pulse_o[g] = q;
  end
endmodule

// File: rtl/freerun_period_timer.sv
module freerun_period_timer
  import freerun_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_period_i,
  input  logic [W-1:0] wr_value_i,
  input  logic         wr_ctrl_i,
  input  logic         ctrl_updown_i,
  input  logic         ctrl_buffer_i,
  input  logic         ctrl_run_i,
  input  logic         count_en_i,
  output logic [W-1:0] count_o,
  output logic         match_o,
  output logic         zero_o
);
  localparam int NEVT = 2;

  cnt_mode_e    mode_q;
  logic         bfe_q;
  logic         run_q;
  logic         step;
  logic         load_evt;
  logic         match_evt;
  logic         zero_evt;
  logic         down_q;
  logic [W-1:0] period_q;
  logic [W-1:0] cnt;
  logic [NEVT-1:0] pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CNT_UP;
      bfe_q  <= 1'b0;
      run_q  <= 1'b0;
    end else if (wr_ctrl_i) begin
      mode_q <= ctrl_updown_i ? CNT_UPDOWN : CNT_UP;
      bfe_q  <= ctrl_buffer_i;
      run_q  <= ctrl_run_i;
    end
  end

  assign step     = run_q && count_en_i;
  assign load_evt = zero_evt && bfe_q;

  freerun_period_regs #(.W(W)) u_period (
    .clk(clk), .rst_n(rst_n), .wr_period_i(wr_period_i),
    .wr_value_i(wr_value_i), .buffered_i(bfe_q), .load_i(load_evt),
    .period_o(period_q)
  );

  freerun_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .step_i(step), .mode_i(mode_q),
    .period_i(period_q), .cnt_o(cnt), .down_o(down_q),
    .match_evt_o(match_evt), .zero_evt_o(zero_evt)
  );

  freerun_event_pulse #(.N(NEVT)) u_pulse (
    .clk(clk), .rst_n(rst_n), .evt_i({zero_evt, match_evt}),
    .pulse_o(pulses)
  );

  assign count_o = cnt;
  assign match_o = pulses[0];
  assign zero_o  = pulses[1];
endmodule

// File: rtl/freerun_period_timer_chk.sv
module freerun_period_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         updown,
  input logic         bfe_q,
  input logic         load_evt,
  input logic         wr_period_i,
  input logic [W-1:0] wr_value_i,
  input logic [W-1:0] period_q,
  input logic [W-1:0] count_o,
  input logic         match_o,
  input logic         zero_o
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(count_o) && !match_o && !zero_o));

  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !updown && count_o == period_q) |=> (count_o == '0));

  p_up_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !updown && count_o != period_q) |=> (count_o == $past(count_o) + 1'b1));

  p_turn_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && updown && count_o == period_q && period_q != '0)
    |=> (count_o == $past(count_o) - 1'b1));

  p_match_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_o == period_q) |=> match_o);

  p_zero_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_o == '0) |=> zero_o);

  p_direct_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_period_i && !bfe_q) |=> (period_q == $past(wr_value_i)));

  p_buffer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bfe_q && !load_evt) |=> $stable(period_q));
endmodule

bind freerun_period_timer freerun_period_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .updown(mode_q == freerun_pkg::CNT_UPDOWN),
  .bfe_q(bfe_q), .load_evt(load_evt), .wr_period_i(wr_period_i),
  .wr_value_i(wr_value_i), .period_q(period_q), .count_o(count_o),
  .match_o(match_o), .zero_o(zero_o)
);

// File: tb/freerun_period_timer_tb_top.sv
module freerun_period_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_period_i = 1'b0;
  logic [15:0] wr_value_i = '0;
  logic        wr_ctrl_i = 1'b0;
  logic        ctrl_updown_i = 1'b0;
  logic        ctrl_buffer_i = 1'b0;
  logic        ctrl_run_i = 1'b0;
  logic        count_en_i = 1'b0;
  logic [15:0] count_o;
  logic        match_o;
  logic        zero_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  freerun_period_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_period_i(wr_period_i), .wr_value_i(wr_value_i),
    .wr_ctrl_i(wr_ctrl_i), .ctrl_updown_i(ctrl_updown_i), .ctrl_buffer_i(ctrl_buffer_i),
    .ctrl_run_i(ctrl_run_i), .count_en_i(count_en_i), .count_o(count_o),
    .match_o(match_o), .zero_o(zero_o)
  );

  // {wp, wc, ud, bf, run, en} value, expected count, {match, zero}
  localparam int NV = 32;
  localparam logic [39:0] TBL [NV] = '{
    {6'b000001, 16'd0, 16'd0, 2'b00},
    {6'b100001, 16'd3, 16'd0, 2'b00},
    {6'b010011, 16'd0, 16'd0, 2'b00},
    {6'b000001, 16'd0, 16'd1, 2'b01},
    {6'b000001, 16'd0, 16'd2, 2'b00},
    {6'b000001, 16'd0, 16'd3, 2'b00},
    {6'b000001, 16'd0, 16'd0, 2'b10},
    {6'b000001, 16'd0, 16'd1, 2'b01},
    {6'b000000, 16'd0, 16'd1, 2'b00},
    {6'b011011, 16'd0, 16'd2, 2'b00},
    {6'b000001, 16'd0, 16'd3, 2'b00},
    {6'b000001, 16'd0, 16'd2, 2'b10},
    {6'b000001, 16'd0, 16'd1, 2'b00},
    {6'b000001, 16'd0, 16'd0, 2'b00},
    {6'b000001, 16'd0, 16'd1, 2'b01},
    {6'b000001, 16'd0, 16'd2, 2'b00},
    {6'b000001, 16'd0, 16'd3, 2'b00},
    {6'b000001, 16'd0, 16'd2, 2'b10},
    {6'b010011, 16'd0, 16'd1, 2'b00},
    {6'b000001, 16'd0, 16'd2, 2'b00},
    {6'b000001, 16'd0, 16'd3, 2'b00},
    {6'b000001, 16'd0, 16'd0, 2'b10},
    {6'b010111, 16'd0, 16'd1, 2'b01},
    {6'b100001, 16'd5, 16'd2, 2'b00},
    {6'b000001, 16'd0, 16'd3, 2'b00},
    {6'b000001, 16'd0, 16'd0, 2'b10},
    {6'b000001, 16'd0, 16'd1, 2'b01},
    {6'b000001, 16'd0, 16'd2, 2'b00},
    {6'b000001, 16'd0, 16'd3, 2'b00},
    {6'b000001, 16'd0, 16'd4, 2'b00},
    {6'b000001, 16'd0, 16'd5, 2'b00},
    {6'b000001, 16'd0, 16'd0, 2'b10}
  };

  function automatic string vec_req(input int i);
    if (i <= 2)  return "R1";
    if (i == 8)  return "R2";
    if (i <= 7)  return "R3";
    if (i == 9)  return "R9";
    if (i <= 17) return "R4";
    if (i <= 21) return "R8";
    return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [15:0] ec,
                           input logic em, input logic ez);
    check(req, "count", count_o, ec);
    check(req, "match", {15'd0, match_o}, {15'd0, em});
    check(req, "zero", {15'd0, zero_o}, {15'd0, ez});
  endtask

  // apply inputs for exactly one rising edge; returns at the following falling edge
  task automatic drive(input logic wp, input logic wc, input logic ud, input logic bf,
                       input logic run, input logic en, input logic [15:0] val);
    wr_period_i = wp; wr_ctrl_i = wc; ctrl_updown_i = ud; ctrl_buffer_i = bf;
    ctrl_run_i = run; count_en_i = en; wr_value_i = val;
    @(negedge clk);
    wr_period_i = 1'b0; wr_ctrl_i = 1'b0; count_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    do_reset();
    check_all("R1", 16'd0, 1'b0, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = TBL[i];
      drive(v[39], v[38], v[37], v[36], v[35], v[34], v[33:18]);
      check_all(vec_req(i), v[17:2], v[1], v[0]);
    end

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    #1;
    check_all("R1", 16'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
    check_all("R1", 16'd0, 1'b0, 1'b0);

    // R6: lower the period directly while running
    do_reset();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0);
    for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
    check("R6", "count before write", count_o, 16'd4);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd6);
    check("R6", "count at write", count_o, 16'd5);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
    check("R6", "count", count_o, 16'd6);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
    check_all("R6", 16'd0, 1'b1, 1'b0);

    // R10: pending buffered value replaced by a direct write
    do_reset();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd4);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd9);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] e;
      e = 16'((k + 1) % 3);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
      check_all("R10", e, (e == 16'd0), (e == 16'd1));
    end

    // R11: zero period in up/down mode
    do_reset();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd0);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
      check_all("R11", 16'd0, 1'b1, 1'b1);
    end

    finish_run();
  end
endmodule